// File: doc/BRIEF.md
# Crowbar Overvoltage Clamp Controller

This block is the last line of defence against a runaway output rail. It watches a digitized output voltage, given in millivolts, against two fixed levels: a high trip level and a much lower release level. When the output climbs past the trip level, the block acts at once. There is no qualification delay. It forces the low-side switches on to pull the output down, and it marks the rail as faulted so that power-good is held low. When the output has dropped beneath the release level, every switch is turned off. This keeps the output from ringing below ground. If the output rises past the trip level again, the clamp engages once more.

The fault is not cleared by taking the controller's enable low. Only a loss of supply-good returns the block to its idle state. The trip detector is live whenever the controller is enabled, even after a different fault has already shut the regulator down. While the clamp owns the switches, its command overrides whatever the fault supervisor asks for.

Top module: `ovp_crowbar`

## Requirements
- R1: While reset is asserted and after its release, `ls_force`, `all_off` and `ovp_fault` are 0 and the block is idle.
- R2: When idle, with `ctl_en`=1 and `supply_ok`=1, a sample with `vout_mv` strictly above `TRIP_MV` (default 1700) raises `ls_force` and `ovp_fault` on the next clock edge. A sample equal to `TRIP_MV` does not trip.
- R3: When idle with `ctl_en`=0, an overvoltage sample has no effect: all three override outputs stay 0.
- R4: While clamping, a sample strictly below `REL_MV` (default 850) moves the block to released on the next edge, with `ls_force`=0, `all_off`=1 and `ovp_fault` still 1. A sample equal to `REL_MV` keeps the clamp.
- R5: When released, with `ctl_en`=1, a sample above `TRIP_MV` re-enters the clamp on the next edge. With `ctl_en`=0 the block stays released.
- R6: Taking `ctl_en` low never clears the clamp or released state, and never clears `ovp_fault`.
- R7: `supply_ok`=0 sampled at an edge returns the block to idle with all overrides 0, from any state. It wins over a simultaneous overvoltage.
- R8: When idle, `hs_gate_on` and `ls_gate_on` equal `sup_hs_on` and `sup_ls_on`.
- R9: While clamping, `ls_gate_on`=1 and `hs_gate_on`=0. While released, both are 0. In both cases the supervisor commands are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| vout_mv | input | 12 | Output voltage sample in millivolts, unsigned, new every clock |
| ctl_en | input | 1 | Controller enabled |
| supply_ok | input | 1 | Supply-good; low clears the fault |
| sup_hs_on | input | 1 | High-side command from the fault supervisor |
| sup_ls_on | input | 1 | Low-side command from the fault supervisor |
| ls_force | output | 1 | Override: low-side switches forced on |
| all_off | output | 1 | Override: every switch forced off |
| ovp_fault | output | 1 | Latched fault; power-good must be low while set |
| hs_gate_on | output | 1 | Final high-side command after the override |
| ls_gate_on | output | 1 | Final low-side command after the override |

## Verification
The assertions assume that `vout_mv` and the control inputs are stable through each rising edge and carry a fresh, valid sample every cycle. They also assume `supply_ok` is an ordinary synchronous level rather than a glitch. The stimulus changes every input only on the falling clock edge. It holds values long enough for each state to be entered and observed. It steps the voltage through the exact threshold values and the values on either side of them. It also toggles enable and supply-good both in and out of the fault states, so every transition the assertions guard is reached from a legal input history.

// File: rtl/ovp_pkg.sv
package ovp_pkg;
  typedef enum logic [1:0] {
    OVP_IDLE     = 2'd0,
    OVP_CLAMP    = 2'd1,
    OVP_RELEASED = 2'd2
  } ovp_state_e;
endpackage

// File: rtl/ovp_window_cmp.sv
module ovp_window_cmp #(
  parameter int W      = 12,
  parameter int TRIP_MV = 1700,
  parameter int REL_MV  = 850
) (
  input  logic [W-1:0] sample,
  output logic         over_trip,
  output logic         under_rel
);
  localparam logic [W-1:0] TRIP_V = W'(TRIP_MV);
  localparam logic [W-1:0] REL_V  = W'(REL_MV);

  always_comb begin
    over_trip = (sample > TRIP_V);
    under_rel = (sample < REL_V);
  end
endmodule

// File: rtl/ovp_clamp_fsm.sv
module ovp_clamp_fsm
  import ovp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_en,
  input  logic       supply_ok,
  input  logic       over_trip,
  input  logic       under_rel,
  output ovp_state_e state
);
  ovp_state_e state_nx;

  always_comb begin
    state_nx = state;
    if (!supply_ok) begin
      state_nx = OVP_IDLE;
    end else begin
      unique case (state)
        OVP_IDLE:     if (ctl_en && over_trip) state_nx = OVP_CLAMP;
        OVP_CLAMP:    if (under_rel)           state_nx = OVP_RELEASED;
        OVP_RELEASED: if (ctl_en && over_trip) state_nx = OVP_CLAMP;
        default:                               state_nx = OVP_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= OVP_IDLE;
    else        state <= state_nx;
  end

  a_r2_trip_now: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && ctl_en && over_trip && state != OVP_CLAMP) |=> (state == OVP_CLAMP));
  a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && state == OVP_CLAMP && under_rel) |=> (state == OVP_RELEASED));
  a_r6_enable_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && !ctl_en && state != OVP_IDLE) |=> (state != OVP_IDLE));
  a_r7_supply_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!supply_ok) |=> (state == OVP_IDLE));
  a_r3_no_trip_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (state == OVP_IDLE && !ctl_en) |=> (state == OVP_IDLE));
endmodule

// File: rtl/ovp_gate_mux.sv
module ovp_gate_mux
  import ovp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  ovp_state_e state,
  input  logic       sup_hs_on,
  input  logic       sup_ls_on,
  output logic       ls_force,
  output logic       all_off,
  output logic       ovp_fault,
  output logic       hs_gate_on,
  output logic       ls_gate_on
);
  always_comb begin
    ls_force  = (state == OVP_CLAMP);
    all_off   = (state == OVP_RELEASED);
    ovp_fault = ls_force | all_off;
    if (ls_force) begin
      hs_gate_on = 1'b0;
      ls_gate_on = 1'b1;
    end else if (all_off) begin
      hs_gate_on = 1'b0;
      ls_gate_on = 1'b0;
    end else begin
      hs_gate_on = sup_hs_on;
      ls_gate_on = sup_ls_on;
    end
  end

  a_r9_clamp_gates: assert property (@(posedge clk) disable iff (!rst_n)
    ls_force |-> (ls_gate_on && !hs_gate_on));
  a_r9_off_gates: assert property (@(posedge clk) disable iff (!rst_n)
    all_off |-> (!ls_gate_on && !hs_gate_on));
  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ls_force && all_off));
endmodule

// File: rtl/ovp_crowbar.sv
module ovp_crowbar
  import ovp_pkg::*;
#(
  parameter int W       = 12,
  parameter int TRIP_MV = 1700,
  parameter int REL_MV  = 850
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] vout_mv,
  input  logic         ctl_en,
  input  logic         supply_ok,
  input  logic         sup_hs_on,
  input  logic         sup_ls_on,
  output logic         ls_force,
  output logic         all_off,
  output logic         ovp_fault,
  output logic         hs_gate_on,
  output logic         ls_gate_on
);
  logic       over_trip;
  logic       under_rel;
  ovp_state_e state;

  ovp_window_cmp #(.W(W), .TRIP_MV(TRIP_MV), .REL_MV(REL_MV)) u_cmp (
    .sample    (vout_mv),
    .over_trip (over_trip),
    .under_rel (under_rel)
  );

  ovp_clamp_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_en    (ctl_en),
    .supply_ok (supply_ok),
    .over_trip (over_trip),
    .under_rel (under_rel),
    .state     (state)
  );

  ovp_gate_mux u_mux (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state),
    .sup_hs_on  (sup_hs_on),
    .sup_ls_on  (sup_ls_on),
    .ls_force   (ls_force),
    .all_off    (all_off),
    .ovp_fault  (ovp_fault),
    .hs_gate_on (hs_gate_on),
    .ls_gate_on (ls_gate_on)
  );

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == OVP_IDLE) |-> (!ls_force && !all_off && !ovp_fault));
  a_r8_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovp_fault) |-> (hs_gate_on == sup_hs_on && ls_gate_on == sup_ls_on));
endmodule

// File: tb/tb_ovp_crowbar.sv
module tb_ovp_crowbar;
  logic        clk;
  logic        rst_n;
  logic [11:0] vout_mv;
  logic        ctl_en, supply_ok, sup_hs_on, sup_ls_on;
  logic        ls_force, all_off, ovp_fault, hs_gate_on, ls_gate_on;

  typedef struct {
    logic [4:0] exp;
    string      req;
  } item_t;

  item_t q[$];
  int    n_cmp  = 0;
  int    n_bad  = 0;
  int    mstate = 0;
  bit    done   = 0;

  ovp_crowbar dut (
    .clk(clk), .rst_n(rst_n), .vout_mv(vout_mv), .ctl_en(ctl_en),
    .supply_ok(supply_ok), .sup_hs_on(sup_hs_on), .sup_ls_on(sup_ls_on),
    .ls_force(ls_force), .all_off(all_off), .ovp_fault(ovp_fault),
    .hs_gate_on(hs_gate_on), .ls_gate_on(ls_gate_on)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [4:0] expect_out(int st, logic hs, logic ls);
    case (st)
      1:       return {1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
      2:       return {1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
      default: return {1'b0, 1'b0, 1'b0, hs, ls};
    endcase
  endfunction

  task automatic drive(input int v, input logic en, input logic sok,
                       input logic hs, input logic ls, input string req);
    item_t it;
    @(negedge clk);
    vout_mv = 12'(v); ctl_en = en; supply_ok = sok; sup_hs_on = hs; sup_ls_on = ls;
    if (!sok) mstate = 0;
    else if (mstate == 0 && en && v > 1700) mstate = 1;
    else if (mstate == 1 && v < 850) mstate = 2;
    else if (mstate == 2 && en && v > 1700) mstate = 1;
    it.exp = expect_out(mstate, hs, ls);
    it.req = req;
    q.push_back(it);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #3;
      if (q.size() > 0) begin
        item_t it;
        logic [4:0] act;
        it = q.pop_front();
        act = {ls_force, all_off, ovp_fault, hs_gate_on, ls_gate_on};
        n_cmp++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s: got %b expected %b", it.req, act, it.exp);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : stim
    rst_n = 1'b0; vout_mv = '0; ctl_en = 1'b0; supply_ok = 1'b1;
    sup_hs_on = 1'b0; sup_ls_on = 1'b0;
    repeat (3) @(negedge clk);
    n_cmp++;
    if ({ls_force, all_off, ovp_fault} !== 3'b000) begin
      n_bad++;
      $display("FAIL R1: got %b expected 000", {ls_force, all_off, ovp_fault});
    end
    @(negedge clk); rst_n = 1'b1;
    drive(1000, 1, 1, 0, 0, "R1");
    // R8 passthrough patterns
    drive(1200, 1, 1, 1, 0, "R8");
    drive(1200, 1, 1, 0, 1, "R8");
    drive(1200, 1, 1, 1, 1, "R8");
    // R2 exact threshold does not trip
    drive(1700, 1, 1, 1, 0, "R2");
    // R3 disabled ignores overvoltage
    drive(2500, 0, 1, 0, 1, "R3");
    drive(4095, 0, 1, 1, 0, "R3");
    // R2 trip just above
    drive(1701, 1, 1, 1, 0, "R2");
    // R9 clamp ignores supervisor
    drive(1600, 1, 1, 1, 0, "R9");
    drive(1200, 1, 1, 0, 0, "R9");
    // R4 exact release level stays clamped
    drive(850, 1, 1, 1, 1, "R4");
    // R6 enable low keeps clamp
    drive(900, 0, 1, 0, 1, "R6");
    // R4 release
    drive(849, 1, 1, 1, 1, "R4");
    drive(300, 1, 1, 1, 1, "R9");
    // R6 enable low keeps released
    drive(200, 0, 1, 1, 1, "R6");
    // R5 disabled: no re-clamp
    drive(2000, 0, 1, 0, 0, "R5");
    // R5 re-clamp
    drive(1800, 1, 1, 0, 0, "R5");
    drive(1800, 0, 1, 1, 0, "R6");
    // R7 supply loss clears
    drive(1800, 1, 0, 1, 0, "R7");
    drive(3000, 1, 0, 0, 1, "R7");
    drive(1000, 1, 1, 1, 1, "R8");
    // full cycle again then clear from released
    drive(1750, 1, 1, 0, 0, "R2");
    drive(100, 1, 1, 0, 0, "R4");
    drive(100, 1, 0, 1, 0, "R7");
    drive(100, 1, 1, 0, 1, "R8");
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule